// File: doc/BRIEF.md
# Query Response Width Adapter

This block produces the read word returned while a parallel flash bank is in its capability-query mode or its identifier mode. The bank is made of several identical devices side by side. Each device may run narrower than its widest mode. A request carries a bus byte offset, an access width and a mode bit. Three plain configuration pins give the bank width, the width each device runs at, and the widest width the device supports. The block turns the offset into a per-device table index, fetches a capability byte from a table supplied on a flat input, or picks one of two 16-bit identifier codes. It then builds the word one device would return, copies that word into every device slice of the bank, and fills a wider access with several consecutive bank responses.

Requests and responses use valid/ready. A request is taken when `req_valid` and `req_ready` are both high. Its response appears registered on the next cycle and stays unchanged until `resp_ready` is seen high. `req_ready` goes low only while an unaccepted response is being held, so one response can be in flight with no bubble. The configuration pins, the table input and the identifier codes are sampled together with the request. Width pins carry a byte count of 1, 2 or 4. A device width of 0 selects the legacy path. `OFS_W` must be at least 8 and `TBL_LEN` at most 256.

Top module: `qry_width_adapter`

## Requirements
- R1: A request accepted on a clock edge gives `resp_valid` high after that edge. `req_ready` is low exactly when `resp_valid` is high and `resp_ready` is low. A response taken with no new request leaves `resp_valid` low on the next cycle.
- R2: While `resp_valid` is high and `resp_ready` is low, `resp_data` and `resp_valid` hold their values, and a request offered meanwhile is not taken.
- R3: With device width d, bank width b and widest width w (all nonzero), the table index is the offset shifted right by log2(b) + log2(w) − log2(d). In capability mode (`req_mode`=0), the selected table byte is returned in byte 0 of a one-device word.
- R4: A capability index of `TBL_LEN` or more reads as byte 0x00.
- R5: In capability mode with d=1 and w>1, the table byte fills every byte lane of the bank. With d=w>1, the device word is the table byte in its low byte and zeros above it.
- R6: The device word is copied into each d-byte slice of the b-byte bank word, lane m of the bank taking device byte (m mod d).
- R7: When the access width a exceeds b, bank slice k (bytes k·b up to k·b+b−1 of the result) is the response for offset + k·b.
- R8: In identifier mode (`req_mode`=1), index bits [7:0] of 0 select `id_mfr` and 1 selects `id_dev`. Other values select zero. The device word is the low d bytes of the 16-bit code, zero-extended, and R6 and R7 then apply.
- R9: With d=0 the index is offset[7:0], shifted right 1 for b=2 and 2 for b=4. Capability mode returns the table byte (zero if out of range) and identifier mode returns the 16-bit code (index 0 manufacturer, 1 device, else zero), with no replication or packing.
- R10: The response is zero when a or b is not 1, 2 or 4. With d nonzero it is also zero when d or w is not 1, 2 or 4, when log2(b)+log2(w) < log2(d), or, in capability mode only, when d≠w and d≠1.
- R11: Result bytes at positions a and above are zero.
- R12: During reset `resp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 1 | 0 capability query, 1 identifier |
| req_offset | input | OFS_W | Bus byte offset |
| req_acc_w | input | 3 | Access width in bytes |
| cfg_bank_w | input | 3 | Bank width in bytes |
| cfg_dev_w | input | 3 | Device operating width in bytes, 0 for legacy |
| cfg_max_dev_w | input | 3 | Widest device width in bytes |
| tbl_bytes | input | TBL_LEN*8 | Capability table, byte i at bits [8i+7:8i] |
| id_mfr | input | 16 | Manufacturer code |
| id_dev | input | 16 | Device code |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_data | output | 32 | Response word |

## Verification
The only state is the response register, so any fault in the index shift, lane selection, replication or packing shows as a wrong `resp_data` word on the first cycle after the request that triggers it. No later request is affected. A fault in the valid register shows at once as a missing response, a lost response under back-pressure, or a `req_ready` that stays low after the response is taken. The sweep covers every legal and several illegal width combinations, and table indices on both sides of the table end. Each response word is compared against its arithmetic expectation.

// File: rtl/qwa_pkg.sv
package qwa_pkg;
  localparam int QWA_BYTES = 4;

  typedef enum logic {QWA_CAP = 1'b0, QWA_ID = 1'b1} qwa_mode_e;

  function automatic logic width_ok(input logic [2:0] w);
    return (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
  endfunction

  function automatic logic [1:0] width_lg(input logic [2:0] w);
    case (w)
      3'd2:    return 2'd1;
      3'd4:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/qwa_slice.sv
module qwa_slice
  import qwa_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int TBL_LEN = 82,
  parameter int SLICE   = 0
) (
  input  logic [OFS_W-1:0]     offset,
  input  qwa_mode_e            mode,
  input  logic [2:0]           bank_w,
  input  logic [2:0]           dev_w,
  input  logic [2:0]           shift,
  input  logic [TBL_LEN*8-1:0] tbl_bytes,
  input  logic [15:0]          id_mfr,
  input  logic [15:0]          id_dev,
  output logic [31:0]          word
);
  localparam int AW = OFS_W + 3;

  logic [AW-1:0] off_k;
  logic [AW-1:0] idx;
  logic [7:0]    tbyte;
  logic [31:0]   code;
  logic [7:0]    dbytes [QWA_BYTES];
  logic [1:0]    dmask;

  always_comb begin
    off_k = AW'(offset) + AW'(SLICE) * AW'(bank_w);
    idx   = off_k >> shift;
    tbyte = 8'h00;
    for (int i = 0; i < TBL_LEN; i++) begin
      if (idx == AW'(i)) tbyte = tbl_bytes[i*8 +: 8];
    end
    if (idx[7:0] == 8'd0)      code = {16'h0000, id_mfr};
    else if (idx[7:0] == 8'd1) code = {16'h0000, id_dev};
    else                       code = 32'h0;
    for (int b = 0; b < QWA_BYTES; b++) begin
      if (mode == QWA_ID) dbytes[b] = (3'(b) < dev_w) ? code[b*8 +: 8] : 8'h00;
      else                dbytes[b] = (b == 0) ? tbyte : 8'h00;
    end
    dmask = 2'(dev_w - 3'd1);
    for (int m = 0; m < QWA_BYTES; m++) begin
      word[m*8 +: 8] = (3'(m) < bank_w) ? dbytes[2'(m) & dmask] : 8'h00;
    end
  end
endmodule

// File: rtl/qwa_legacy.sv
module qwa_legacy
  import qwa_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int TBL_LEN = 82
) (
  input  logic [OFS_W-1:0]     offset,
  input  qwa_mode_e            mode,
  input  logic [2:0]           bank_w,
  input  logic [TBL_LEN*8-1:0] tbl_bytes,
  input  logic [15:0]          id_mfr,
  input  logic [15:0]          id_dev,
  output logic [31:0]          word
);
  logic [7:0] idx8;
  logic [7:0] tbyte;

  always_comb begin
    idx8  = offset[7:0] >> width_lg(bank_w);
    tbyte = 8'h00;
    for (int i = 0; i < TBL_LEN; i++) begin
      if (idx8 == 8'(i)) tbyte = tbl_bytes[i*8 +: 8];
    end
    if (mode == QWA_CAP)    word = {24'h0, tbyte};
    else if (idx8 == 8'd0)  word = {16'h0, id_mfr};
    else if (idx8 == 8'd1)  word = {16'h0, id_dev};
    else                    word = 32'h0;
  end
endmodule

// File: rtl/qry_width_adapter.sv
module qry_width_adapter
  import qwa_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int TBL_LEN = 82
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_mode,
  input  logic [OFS_W-1:0]     req_offset,
  input  logic [2:0]           req_acc_w,
  input  logic [2:0]           cfg_bank_w,
  input  logic [2:0]           cfg_dev_w,
  input  logic [2:0]           cfg_max_dev_w,
  input  logic [TBL_LEN*8-1:0] tbl_bytes,
  input  logic [15:0]          id_mfr,
  input  logic [15:0]          id_dev,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic [31:0]          resp_data
);
  qwa_mode_e   mode;
  logic [2:0]  sum_up;
  logic [2:0]  shift;
  logic        base_ok, wide_ok, mismatch;
  logic [31:0] sw [QWA_BYTES];
  logic [31:0] leg_word, packed_word, pick, result;
  logic [1:0]  k_sel, m_sel;

  assign mode = qwa_mode_e'(req_mode);

  always_comb begin
    sum_up   = {1'b0, width_lg(cfg_bank_w)} + {1'b0, width_lg(cfg_max_dev_w)};
    shift    = sum_up - {1'b0, width_lg(cfg_dev_w)};
    base_ok  = width_ok(req_acc_w) && width_ok(cfg_bank_w);
    wide_ok  = width_ok(cfg_dev_w) && width_ok(cfg_max_dev_w) &&
               (sum_up >= {1'b0, width_lg(cfg_dev_w)});
    mismatch = (mode == QWA_CAP) && (cfg_dev_w != cfg_max_dev_w) && (cfg_dev_w != 3'd1);
  end

  for (genvar k = 0; k < QWA_BYTES; k++) begin : g_slice
    qwa_slice #(.OFS_W(OFS_W), .TBL_LEN(TBL_LEN), .SLICE(k)) u_slice (
      .offset    (req_offset),
      .mode      (mode),
      .bank_w    (cfg_bank_w),
      .dev_w     (cfg_dev_w),
      .shift     (shift),
      .tbl_bytes (tbl_bytes),
      .id_mfr    (id_mfr),
      .id_dev    (id_dev),
      .word      (sw[k])
    );
  end

  qwa_legacy #(.OFS_W(OFS_W), .TBL_LEN(TBL_LEN)) u_legacy (
    .offset    (req_offset),
    .mode      (mode),
    .bank_w    (cfg_bank_w),
    .tbl_bytes (tbl_bytes),
    .id_mfr    (id_mfr),
    .id_dev    (id_dev),
    .word      (leg_word)
  );

  always_comb begin
    k_sel = 2'd0;
    m_sel = 2'd0;
    for (int b = 0; b < QWA_BYTES; b++) begin
      k_sel = 2'(b) >> width_lg(cfg_bank_w);
      m_sel = 2'(b) & 2'(cfg_bank_w - 3'd1);
      packed_word[b*8 +: 8] = sw[k_sel][{m_sel, 3'b000} +: 8];
    end
    if (!base_ok)                   pick = 32'h0;
    else if (cfg_dev_w == 3'd0)     pick = leg_word;
    else if (!wide_ok || mismatch)  pick = 32'h0;
    else                            pick = packed_word;
    for (int b = 0; b < QWA_BYTES; b++) begin
      result[b*8 +: 8] = (3'(b) < req_acc_w) ? pick[b*8 +: 8] : 8'h00;
    end
  end

  assign req_ready = !resp_valid || resp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= 32'h0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (req_valid) resp_data <= result;
    end
  end
endmodule

// File: rtl/qwa_checker.sv
module qwa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_acc_w,
  input logic [2:0]  cfg_bank_w,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_data
);
  logic [2:0] cap_acc;
  logic       cap_bad;
  logic [31:0] acc_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_acc <= 3'd4;
      cap_bad <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_acc <= req_acc_w;
      cap_bad <= !qwa_pkg::width_ok(req_acc_w) || !qwa_pkg::width_ok(cfg_bank_w);
    end
  end

  always_comb begin
    case (cap_acc)
      3'd1:    acc_mask = 32'h0000_00FF;
      3'd2:    acc_mask = 32'h0000_FFFF;
      3'd4:    acc_mask = 32'hFFFF_FFFF;
      default: acc_mask = 32'h0;
    endcase
  end

  assert_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && cap_bad |-> resp_data == 32'h0);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_data & ~acc_mask) == 32'h0);
endmodule

bind qry_width_adapter qwa_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_acc_w  (req_acc_w),
  .cfg_bank_w (cfg_bank_w),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_data  (resp_data)
);

// File: tb/qry_width_adapter_tb.sv
module qry_width_adapter_tb;
  localparam int OFS_W   = 12;
  localparam int TBL_LEN = 82;
  localparam logic [15:0] MFR = 16'hA589;
  localparam logic [15:0] DEV = 16'h3C17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n, req_valid, req_ready, req_mode, resp_valid, resp_ready;
  logic [OFS_W-1:0]     req_offset;
  logic [2:0]           req_acc_w, cfg_bank_w, cfg_dev_w, cfg_max_dev_w;
  logic [TBL_LEN*8-1:0] tbl;
  logic [31:0]          resp_data;

  int errs = 0;
  int checks = 0;

  qry_width_adapter #(.OFS_W(OFS_W), .TBL_LEN(TBL_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_offset(req_offset), .req_acc_w(req_acc_w),
    .cfg_bank_w(cfg_bank_w), .cfg_dev_w(cfg_dev_w), .cfg_max_dev_w(cfg_max_dev_w),
    .tbl_bytes(tbl), .id_mfr(MFR), .id_dev(DEV),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data)
  );

  function automatic logic [7:0] tbv(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic bit okw(int w);
    return (w == 1) || (w == 2) || (w == 4);
  endfunction

  function automatic int lgw(int w);
    return (w == 4) ? 2 : (w == 2) ? 1 : 0;
  endfunction

  function automatic logic [31:0] amask(int a);
    return (a == 4) ? 32'hFFFF_FFFF : (a == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [31:0] model(bit mode, int off, int acc, int bank, int dev, int mx);
    logic [31:0] r, d, bw;
    int sh, o, i, j;
    logic [7:0] tb;
    if (!okw(acc) || !okw(bank)) return 32'h0;
    if (dev == 0) begin
      i = (off & 255) >> lgw(bank);
      if (mode) r = (i == 0) ? {16'h0, MFR} : (i == 1) ? {16'h0, DEV} : 32'h0;
      else      r = (i < TBL_LEN) ? {24'h0, tbv(i)} : 32'h0;
      return r & amask(acc);
    end
    if (!okw(dev) || !okw(mx)) return 32'h0;
    sh = lgw(bank) + lgw(mx) - lgw(dev);
    if (sh < 0) return 32'h0;
    if (!mode && dev != mx && dev != 1) return 32'h0;
    r = 32'h0;
    for (int k = 0; k * bank < acc; k++) begin
      o = off + k * bank;
      i = o >> sh;
      if (mode) begin
        j = i & 255;
        d = (j == 0) ? {16'h0, MFR} : (j == 1) ? {16'h0, DEV} : 32'h0;
        d = d & amask(dev);
      end else begin
        tb = (i < TBL_LEN) ? tbv(i) : 8'h00;
        d = {24'h0, tb};
      end
      bw = 32'h0;
      for (int m = 0; m < bank; m++) bw[m*8 +: 8] = d[(m % dev)*8 +: 8];
      r = r | (bw << (8 * k * bank));
    end
    return r & amask(acc);
  endfunction

  function automatic string tagfor(bit mode, int off, int acc, int bank, int dev, int mx);
    int sh;
    if (!okw(acc) || !okw(bank)) return "R10";
    if (dev == 0) return "R9";
    if (!okw(dev) || !okw(mx)) return "R10";
    sh = lgw(bank) + lgw(mx) - lgw(dev);
    if (sh < 0) return "R10";
    if (mode) return "R8";
    if ((off >> sh) >= TBL_LEN) return "R4";
    if (dev != mx) return (dev == 1) ? "R5" : "R10";
    if (acc > bank) return "R7";
    if (bank > dev) return "R6";
    if (dev > 1) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(bit mode, int off, int acc, int bank, int dev, int mx);
    req_mode      = mode;
    req_offset    = OFS_W'(off);
    req_acc_w     = 3'(acc);
    cfg_bank_w    = 3'(bank);
    cfg_dev_w     = 3'(dev);
    cfg_max_dev_w = 3'(mx);
  endtask

  task automatic run(bit mode, int off, int acc, int bank, int dev, int mx);
    logic [31:0] exp;
    exp = model(mode, off, acc, bank, dev, mx);
    @(negedge clk);
    drive(mode, off, acc, bank, dev, mx);
    req_valid  = 1'b1;
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "resp_valid after accept", {31'h0, resp_valid}, 32'h1);
    check(tagfor(mode, off, acc, bank, dev, mx), "resp_data", resp_data, exp);
    if (okw(acc) && acc < 4)
      check("R11", "bytes above access width", resp_data & ~amask(acc), 32'h0);
  endtask

  task automatic sweep_offsets(bit mode, int acc, int bank, int dev, int mx);
    for (int o = 0; o < 24; o++) run(mode, o, acc, bank, dev, mx);
    for (int s = 0; s < 5; s++) begin
      run(mode, (TBL_LEN - 1) << s, acc, bank, dev, mx);
      run(mode, TBL_LEN << s, acc, bank, dev, mx);
    end
    run(mode, 'h104, acc, bank, dev, mx);
    run(mode, 'h1FD, acc, bank, dev, mx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] e1, e2;
    int widths [3] = '{1, 2, 4};
    int devs [4] = '{0, 1, 2, 4};
    for (int i = 0; i < TBL_LEN; i++) tbl[i*8 +: 8] = tbv(i);
    rst_n = 1'b0;
    req_valid = 1'b0;
    resp_ready = 1'b1;
    drive(1'b0, 0, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R12", "resp_valid in reset", {31'h0, resp_valid}, 32'h0);
    check("R12", "req_ready in reset", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;

    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int d = 0; d < 4; d++)
            for (int x = 0; x < 3; x++)
              sweep_offsets(md[0], widths[a], widths[b], devs[d], widths[x]);

    // R10: illegal width codes
    run(1'b0, 17, 3, 1, 1, 1);
    run(1'b1, 0, 0, 2, 2, 2);
    run(1'b0, 17, 4, 3, 1, 1);
    run(1'b1, 0, 4, 4, 3, 4);
    run(1'b0, 17, 4, 4, 2, 0);
    run(1'b1, 2, 2, 2, 1, 5);

    // R2 and R1: back-pressure, stall and release
    e1 = model(1'b0, 40, 4, 2, 1, 2);
    e2 = model(1'b1, 0, 4, 2, 2, 2);
    @(negedge clk);
    drive(1'b0, 40, 4, 2, 1, 2);
    req_valid = 1'b1;
    resp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    drive(1'b1, 0, 4, 2, 2, 2);
    for (int c = 0; c < 3; c++) begin
      check("R2", "held resp_data", resp_data, e1);
      check("R2", "held resp_valid", {31'h0, resp_valid}, 32'h1);
      check("R1", "req_ready while stalled", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
    end
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "second response after release", resp_data, e2);
    check("R1", "second resp_valid", {31'h0, resp_valid}, 32'h1);
    @(negedge clk);
    check("R1", "resp_valid drops when idle", {31'h0, resp_valid}, 32'h0);
    check("R1", "req_ready when idle", {31'h0, req_ready}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule